// File: doc/BRIEF.md
# Two-Entry Toggle-Pointer Clock-Crossing FIFO

This block carries multi-bit words from one clock domain to another whose clock bears no fixed relation to the first. Storage is two word slots. Each side owns a single-bit pointer that flips on every transfer it completes. Because a one-bit counter is already a Gray counter, each pointer crosses to the other domain through a plain two-flop synchronizer with no encoding step.

The writer presents a word with a request and sees a ready indication. The reader sees the word together with a data-available indication and takes it with an accept strobe. Each side works out its own indication with a single XOR of its own pointer against the copy of the other side's pointer that has come through the synchronizer. Each domain has its own active-low asynchronous reset. The reset is released in step with that domain's clock.

Top module: `xdom_pingpong_fifo`

## Requirements
- R1: While both resets are asserted, and after they are released with no transfer since, `wr_ready` is 1 and `rd_ready` is 0.
- R2: A word is stored only on a `wr_clk` rising edge where `wr_req` and `wr_ready` are both 1. A request while `wr_ready` is 0 is ignored: its data is never delivered.
- R3: After an accepted write, `wr_ready` is 0 from the next `wr_clk` edge on, until that word has been read and the reader's pointer has come back. At most one word is ever outstanding.
- R4: After a write edge, `rd_ready` rises on the second `rd_clk` rising edge, or on the third when the edges nearly coincide.
- R5: While `rd_ready` is 1, `rd_data` shows the oldest unread word and holds steady until that word is accepted.
- R6: A read takes place only on a `rd_clk` rising edge where `rd_accept` and `rd_ready` are both 1. An accept while `rd_ready` is 0 has no effect.
- R7: Words arrive in the order written, with none lost and none duplicated, whatever the request and accept patterns and the clock ratio.
- R8: After a read edge, `wr_ready` rises on the second `wr_clk` rising edge, or on the third when the edges nearly coincide.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| wr_clk | input | 1 | Write-domain clock |
| wr_rst_n | input | 1 | Write-domain asynchronous reset, active low |
| wr_req | input | 1 | Write request |
| wr_data | input | DATA_W | Word to store |
| wr_ready | output | 1 | A slot is free; a request is taken on this edge |
| rd_clk | input | 1 | Read-domain clock |
| rd_rst_n | input | 1 | Read-domain asynchronous reset, active low |
| rd_accept | input | 1 | Reader takes the presented word |
| rd_data | output | DATA_W | Oldest unread word |
| rd_ready | output | 1 | A word is available |

## Verification
The hardest case to reach is a pointer change that arrives in a domain while the local side is still requesting. Examples are a write request held high just as the returned read pointer lands, or an accept strobe held high across the edge where the write pointer appears. The stimulus sweeps every pairing of three request densities and three accept densities under two unrelated clock ratios. The sweep keeps requests and accepts asserted across those edges, and drives non-matching data during refused writes. Directed steps measure the crossing latency in edges of the receiving clock, in both directions.

// File: rtl/xdom_fifo_pkg.sv
`timescale 1ns/1ps
package xdom_fifo_pkg;
  localparam int unsigned SLOTS = 2;
  localparam int unsigned PTR_W = $clog2(SLOTS);
  typedef logic [PTR_W-1:0] slot_ptr_t;

  // one-bit Gray advance: a toggle
  function automatic slot_ptr_t ptr_step(input slot_ptr_t p);
    return p ^ slot_ptr_t'(1);
  endfunction
endpackage

// File: rtl/xdom_sync.sv
`timescale 1ns/1ps
module xdom_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d,
  output logic q
);
  logic [STAGES-1:0] chain_q;
  logic [STAGES-1:0] chain_d;

  generate
    if (STAGES == 1) begin : g_one
      always_comb chain_d = d;
    end else begin : g_many
      always_comb chain_d = {chain_q[STAGES-2:0], d};
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain_q <= '0;
    else        chain_q <= chain_d;
  end

  assign q = chain_q[STAGES-1];
endmodule

// File: rtl/xdom_store.sv
`timescale 1ns/1ps
module xdom_store
  import xdom_fifo_pkg::*;
#(
  parameter int unsigned DATA_W = 8
) (
  input  logic              clk,
  input  logic              we,
  input  slot_ptr_t         waddr,
  input  logic [DATA_W-1:0] wdata,
  input  slot_ptr_t         raddr,
  output logic [DATA_W-1:0] rdata
);
  logic [DATA_W-1:0] slot_q [SLOTS];
  logic [DATA_W-1:0] slot_d [SLOTS];
  logic [SLOTS-1:0]  slot_en;

  always_comb begin
    for (int i = 0; i < SLOTS; i++) begin
      slot_en[i] = we && (waddr == slot_ptr_t'(i));
      slot_d[i]  = wdata;
    end
  end

  always_ff @(posedge clk) begin
    for (int i = 0; i < SLOTS; i++) begin
      if (slot_en[i]) slot_q[i] <= slot_d[i];
    end
  end

  assign rdata = slot_q[raddr];
endmodule

// File: rtl/xdom_wr_side.sv
`timescale 1ns/1ps
module xdom_wr_side
  import xdom_fifo_pkg::*;
(
  input  logic      clk,
  input  logic      rst_n,
  input  logic      req,
  input  slot_ptr_t far_ptr,
  output slot_ptr_t ptr,
  output logic      ready,
  output logic      take
);
  slot_ptr_t ptr_q, ptr_d;

  assign ready = ~(far_ptr ^ ptr_q);
  assign take  = req & ready;

  always_comb begin
    ptr_d = ptr_q;
    if (take) ptr_d = ptr_step(ptr_q);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) ptr_q <= '0;
    else        ptr_q <= ptr_d;
  end

  assign ptr = ptr_q;

  a_r2_ptr_holds_without_write: assert property (@(posedge clk) disable iff (!rst_n)
    !(req && ready) |=> $stable(ptr_q));
  a_r3_ready_drops_after_write: assert property (@(posedge clk) disable iff (!rst_n)
    (req && ready) |=> !ready);
endmodule

// File: rtl/xdom_rd_side.sv
`timescale 1ns/1ps
module xdom_rd_side
  import xdom_fifo_pkg::*;
(
  input  logic      clk,
  input  logic      rst_n,
  input  logic      accept,
  input  slot_ptr_t far_ptr,
  output slot_ptr_t ptr,
  output logic      ready,
  output logic      take
);
  slot_ptr_t ptr_q, ptr_d;

  assign ready = |(far_ptr ^ ptr_q);
  assign take  = accept & ready;

  always_comb begin
    ptr_d = ptr_q;
    if (take) ptr_d = ptr_step(ptr_q);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) ptr_q <= '0;
    else        ptr_q <= ptr_d;
  end

  assign ptr = ptr_q;

  a_r6_ptr_holds_without_read: assert property (@(posedge clk) disable iff (!rst_n)
    !(accept && ready) |=> $stable(ptr_q));
  a_r6_ready_drops_after_read: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && ready) |=> !ready);
endmodule

// File: rtl/xdom_pingpong_fifo.sv
`timescale 1ns/1ps
module xdom_pingpong_fifo
  import xdom_fifo_pkg::*;
#(
  parameter int unsigned DATA_W      = 8,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic              wr_clk,
  input  logic              wr_rst_n,
  input  logic              wr_req,
  input  logic [DATA_W-1:0] wr_data,
  output logic              wr_ready,
  input  logic              rd_clk,
  input  logic              rd_rst_n,
  input  logic              rd_accept,
  output logic [DATA_W-1:0] rd_data,
  output logic              rd_ready
);
  logic      wr_rst_sync_n, rd_rst_sync_n;
  slot_ptr_t wptr, rptr, wptr_in_rd, rptr_in_wr;
  logic      wr_take, rd_take;

  // reset release aligned to each local clock
  xdom_sync #(.STAGES(SYNC_STAGES)) u_wr_rst (
    .clk(wr_clk), .rst_n(wr_rst_n), .d(1'b1), .q(wr_rst_sync_n));
  xdom_sync #(.STAGES(SYNC_STAGES)) u_rd_rst (
    .clk(rd_clk), .rst_n(rd_rst_n), .d(1'b1), .q(rd_rst_sync_n));

  // pointer crossings, one per bit
  generate
    for (genvar b = 0; b < PTR_W; b++) begin : g_ptr_sync
      xdom_sync #(.STAGES(SYNC_STAGES)) u_r2w (
        .clk(wr_clk), .rst_n(wr_rst_sync_n), .d(rptr[b]), .q(rptr_in_wr[b]));
      xdom_sync #(.STAGES(SYNC_STAGES)) u_w2r (
        .clk(rd_clk), .rst_n(rd_rst_sync_n), .d(wptr[b]), .q(wptr_in_rd[b]));
    end
  endgenerate

  xdom_wr_side u_wr (
    .clk(wr_clk), .rst_n(wr_rst_sync_n), .req(wr_req), .far_ptr(rptr_in_wr),
    .ptr(wptr), .ready(wr_ready), .take(wr_take));

  xdom_rd_side u_rd (
    .clk(rd_clk), .rst_n(rd_rst_sync_n), .accept(rd_accept), .far_ptr(wptr_in_rd),
    .ptr(rptr), .ready(rd_ready), .take(rd_take));

  xdom_store #(.DATA_W(DATA_W)) u_store (
    .clk(wr_clk), .we(wr_take), .waddr(wptr), .wdata(wr_data),
    .raddr(rptr), .rdata(rd_data));

  // R5: presented word is steady while waiting to be taken
  a_r5_data_steady: assert property (@(posedge rd_clk) disable iff (!rd_rst_sync_n)
    (rd_ready && !rd_accept) |=> (rd_ready && $stable(rd_data)));
  // R3: a read completed leaves nothing outstanding
  a_r3_one_outstanding: assert property (@(posedge rd_clk) disable iff (!rd_rst_sync_n)
    rd_take |=> !rd_ready);
endmodule

// File: tb/test_xdom_pingpong_fifo.sv
`timescale 1ns/1ps
module test_xdom_pingpong_fifo;
  localparam int DW = 8;

  logic wr_clk = 1'b0;
  logic rd_clk = 1'b0;
  realtime rd_half = 3.65;
  always #5 wr_clk = ~wr_clk;
  always #(rd_half) rd_clk = ~rd_clk;

  logic          wr_rst_n = 1'b0, rd_rst_n = 1'b0;
  logic          wr_req = 1'b0, rd_accept = 1'b0;
  logic [DW-1:0] wr_data = '0;
  logic [DW-1:0] rd_data;
  logic          wr_ready, rd_ready;

  xdom_pingpong_fifo #(.DATA_W(DW), .SYNC_STAGES(2)) i_xdom_pingpong_fifo (
    .wr_clk(wr_clk), .wr_rst_n(wr_rst_n), .wr_req(wr_req), .wr_data(wr_data),
    .wr_ready(wr_ready), .rd_clk(rd_clk), .rd_rst_n(rd_rst_n),
    .rd_accept(rd_accept), .rd_data(rd_data), .rd_ready(rd_ready));

  int checks = 0, fails = 0;
  bit finished = 1'b0;
  logic [DW-1:0] refq[$];
  logic [DW-1:0] next_val = 8'h10;
  int unsigned rd_edges = 0, wr_edges = 0;
  always @(posedge rd_clk) rd_edges++;
  always @(posedge wr_clk) wr_edges++;

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic run_writer(input int n, input int pct);
    int sent = 0;
    while (sent < n) begin
      @(negedge wr_clk);
      chk(!wr_ready || refq.size() == 0, "R3", "wr_ready with word outstanding",
          refq.size(), 0);
      if ($urandom_range(99) < pct) begin
        wr_req = 1'b1;
        if (wr_ready) begin
          wr_data = next_val;
          refq.push_back(next_val);
          next_val++;
          sent++;
        end else begin
          wr_data = DW'($urandom);  // R2: refused request, must not appear
        end
      end else begin
        wr_req = 1'b0;
      end
    end
    @(negedge wr_clk);
    wr_req = 1'b0;
  endtask

  task automatic run_reader(input int n, input int pct);
    int got = 0;
    while (got < n) begin
      @(negedge rd_clk);
      chk(!rd_ready || refq.size() == 1, "R3", "rd_ready vs words pending",
          refq.size(), 1);
      rd_accept = ($urandom_range(99) < pct);
      if (rd_accept && rd_ready) begin
        chk(refq.size() > 0 && rd_data == refq[0], "R7", "read word order",
            rd_data, refq.size() > 0 ? refq[0] : -1);
        if (refq.size() > 0) void'(refq.pop_front());
        got++;
      end
    end
    @(negedge rd_clk);
    rd_accept = 1'b0;
  endtask

  initial begin
    repeat (190000) @(posedge wr_clk);
    if (!finished) begin
      checks++;
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    int unsigned snap;
    int n;
    // R1 during reset
    repeat (4) @(negedge wr_clk);
    chk(wr_ready === 1'b1, "R1", "wr_ready in reset", wr_ready, 1);
    chk(rd_ready === 1'b0, "R1", "rd_ready in reset", rd_ready, 0);
    wr_rst_n = 1'b1;
    rd_rst_n = 1'b1;
    repeat (6) @(negedge wr_clk);
    chk(wr_ready === 1'b1, "R1", "wr_ready after release", wr_ready, 1);
    chk(rd_ready === 1'b0, "R1", "rd_ready after release", rd_ready, 0);

    // R6: accept while empty is ignored
    rd_accept = 1'b1;
    for (int i = 0; i < 6; i++) begin
      @(negedge rd_clk);
      chk(rd_ready === 1'b0, "R6", "rd_ready with accept on empty", rd_ready, 0);
    end
    rd_accept = 1'b0;

    // one write, then R4 latency
    @(negedge wr_clk);
    wr_req = 1'b1;
    wr_data = 8'hA5;
    @(posedge wr_clk);
    snap = rd_edges;
    @(negedge wr_clk);
    wr_data = 8'h3C;  // R2: held request while not ready
    n = 0;
    @(negedge rd_clk);
    while (!rd_ready && n < 10) begin
      @(negedge rd_clk);
      n++;
    end
    chk(rd_edges - snap >= 2 && rd_edges - snap <= 3, "R4",
        "rd_clk edges to rd_ready", int'(rd_edges - snap), 2);
    for (int i = 0; i < 10; i++) begin
      @(negedge wr_clk);
      chk(wr_ready === 1'b0, "R3", "wr_ready while word unread", wr_ready, 0);
    end
    wr_req = 1'b0;

    // R5: word presented and steady
    for (int i = 0; i < 4; i++) begin
      @(negedge rd_clk);
      chk(rd_ready && rd_data == 8'hA5, "R5", "presented word", rd_data, 8'hA5);
    end

    // read it, then R8 latency
    rd_accept = 1'b1;
    @(posedge rd_clk);
    snap = wr_edges;
    @(negedge rd_clk);
    rd_accept = 1'b0;
    n = 0;
    @(negedge wr_clk);
    while (!wr_ready && n < 10) begin
      @(negedge wr_clk);
      n++;
    end
    chk(wr_edges - snap >= 2 && wr_edges - snap <= 3, "R8",
        "wr_clk edges to wr_ready", int'(wr_edges - snap), 2);
    // R2: refused 0x3C never shows up
    for (int i = 0; i < 8; i++) begin
      @(negedge rd_clk);
      chk(rd_ready === 1'b0, "R2", "no word after refused request", rd_ready, 0);
    end

    // R7 sweep: clock ratios x request densities x accept densities
    for (int c = 0; c < 2; c++) begin
      rd_half = (c == 0) ? 3.65 : 6.85;
      for (int wp = 0; wp < 3; wp++) begin
        for (int rp = 0; rp < 3; rp++) begin
          fork
            run_writer(24, wp == 0 ? 100 : (wp == 1 ? 50 : 20));
            run_reader(24, rp == 0 ? 100 : (rp == 1 ? 50 : 20));
          join
          chk(refq.size() == 0, "R7", "words left undelivered", refq.size(), 0);
          repeat (4) @(negedge rd_clk);
          chk(rd_ready === 1'b0, "R7", "extra word after sweep", rd_ready, 0);
        end
      end
    end

    finished = 1'b1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule